// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the instruction engine of a small 8-bit processor with a 16-bit address space. It keeps one request latch per interrupt source, a master enable flag and a 16-bit stack pointer. When the engine reports that an instruction has finished, the sequencer looks at the pending sources. If one is allowed to run, it takes that source through a fixed eight-cycle entry.

The entry first drops the master enable flag and then clears the source's latch. It pushes three bytes onto a stack that grows toward lower addresses: status with the enable flag in bit 7, then the upper and lower bytes of the program counter. It then reads a two-byte vector, upper byte first, and hands the result to the engine as the new program counter.

A return request runs the opposite four-cycle sequence. It pops the two program counter bytes and then the status byte, which restores the flag. All memory traffic goes through a single byte-wide port whose read data arrives one cycle after the read strobe.

Top module: `irq_seq`

## Requirements
- R1: A request pulse on `reqIn[i]` sets pending bit i, visible on `pend` from the next cycle. The bit stays set until its source is accepted or `latchClr[i]` clears it. When a request and a clear meet in the same cycle, the request wins.
- R2: Acceptance happens only in an idle cycle with `instrDone` high. A source other than source 0 is eligible only while `imf` is 1.
- R3: Source 0 is non-maskable and ignores `imf`. Among eligible sources, the lowest index is accepted.
- R4: The entry occupies the 8 cycles after the accept cycle. `imf` reads 0 from the second of these cycles, and the accepted source's pending bit reads 0 from the third.
- R5: In entry cycles 3, 4 and 5 the block writes, in this order: status `{imf, pswIn[6:0]}` at SP, `pcIn[15:8]` at SP-1, and `pcIn[7:0]` at SP-2. Each write decrements SP afterwards, so SP ends 3 lower. Reads and writes never share a cycle.
- R6: In entry cycles 6 and 7 the block reads addresses FFF4h-2*i and FFF4h-2*i+1. In cycle 8 it raises `done` and `pcLoad` with `pcOut` = {first byte, second byte}.
- R7: After reset SP is 00FFh, `imf` is 0, no bit is pending, and the bus is idle.
- R8: A return runs over 4 cycles. Each of the first three increments SP and reads at the new SP, fetching the low PC byte, then the high PC byte, then status. In the fourth cycle `done`, `pcLoad` and `pswLoad` are high, `pcOut` = {high, low}, `pswOut` = status[6:0], and `imf` takes status bit 7.
- R9: `spWr` and `imfWr` take effect only in an idle cycle that starts no sequence. While a sequence runs they are ignored.
- R10: When `retStart` and an acceptable interrupt arrive in the same idle cycle, the return runs first and the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Request pulses, one per source |
| latchClr | input | NUM_SRC | Software clear of pending bits |
| instrDone | input | 1 | Current instruction has completed |
| retStart | input | 1 | Start a return sequence |
| imfWr | input | 1 | Write the master enable flag |
| imfWrVal | input | 1 | Value for the flag write |
| spWr | input | 1 | Write the stack pointer |
| spWrVal | input | 16 | Value for the stack pointer write |
| pcIn | input | 16 | Program counter to save |
| pswIn | input | 7 | Status bits to save |
| memRdata | input | 8 | Read data, one cycle after `memRe` |
| memAddr | output | 16 | Byte address |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| memWdata | output | 8 | Write data |
| pcLoad | output | 1 | Load `pcOut` into the program counter |
| pcOut | output | 16 | New program counter |
| pswLoad | output | 1 | Load `pswOut` into status |
| pswOut | output | 7 | Restored status bits |
| done | output | 1 | Last cycle of a sequence |
| imf | output | 1 | Master enable flag |
| sp | output | 16 | Stack pointer |
| pend | output | NUM_SRC | Pending request bits |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:
- Same-cycle conflicts: a request meeting a software clear, and a return meeting an acceptable interrupt. A design with the precedence reversed loses the request or enters the interrupt early.
- Masking: maskable sources wait while the flag is 0, and source 0 gets through anyway. A missing mask check produces bus traffic the reference does not expect.
- Byte order: the push order, the high-byte-first vector and the pop order are checked byte by byte. Swapped bytes give a wrong address, wrong write data or a wrong `pcOut`.
- Busy-time writes: stack pointer and flag writes issued during a sequence must leave SP and `imf` unchanged. A design that accepts them shows a divergent SP on the next check.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ENTRY,
    SQ_RETURN
  } seqState_t;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic       swEn;      // software writes allowed this cycle
    logic       snap;      // capture pc and status
    logic       imfClr;
    logic       latchClr;  // clear accepted source
    logic       push;
    logic [1:0] pushSel;   // 0 status, 1 pc high, 2 pc low
    logic       vecRd;
    logic       vecLo;     // second vector byte
    logic       vecHiCap;
    logic       popRd;
    logic       popLoCap;
    logic       popHiCap;
    logic       entryFin;
    logic       retFin;
  } dpCtl_t;

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrDone,
  input  logic               retStart,
  input  logic [NUM_SRC-1:0] eligible,
  output dpCtl_t             ctl,
  output logic [SRC_W-1:0]   srcIdx
);
  localparam logic [2:0] ENTRY_LAST = 3'd7;
  localparam logic [2:0] RET_LAST   = 3'd3;

  seqState_t        state;
  logic [2:0]       step;
  logic [SRC_W-1:0] pick;
  logic             acceptNow;

  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) pick = SRC_W'(i);
    end
  end

  assign acceptNow = instrDone && (|eligible);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SQ_IDLE;
      step   <= '0;
      srcIdx <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          step <= '0;
          if (retStart) begin
            state <= SQ_RETURN;
          end else if (acceptNow) begin
            state  <= SQ_ENTRY;
            srcIdx <= pick;
          end
        end
        SQ_ENTRY: begin
          if (step == ENTRY_LAST) begin
            state <= SQ_IDLE;
            step  <= '0;
          end else begin
            step <= step + 3'd1;
          end
        end
        SQ_RETURN: begin
          if (step == RET_LAST) begin
            state <= SQ_IDLE;
            step  <= '0;
          end else begin
            step <= step + 3'd1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    case (state)
      SQ_IDLE:  ctl.swEn = !(retStart || acceptNow);
      SQ_ENTRY: begin
        case (step)
          3'd0: begin ctl.snap = 1'b1; ctl.imfClr = 1'b1; end
          3'd1: ctl.latchClr = 1'b1;
          3'd2: begin ctl.push = 1'b1; ctl.pushSel = 2'd0; end
          3'd3: begin ctl.push = 1'b1; ctl.pushSel = 2'd1; end
          3'd4: begin ctl.push = 1'b1; ctl.pushSel = 2'd2; end
          3'd5: ctl.vecRd = 1'b1;
          3'd6: begin ctl.vecRd = 1'b1; ctl.vecLo = 1'b1; ctl.vecHiCap = 1'b1; end
          default: ctl.entryFin = 1'b1;
        endcase
      end
      SQ_RETURN: begin
        case (step)
          3'd0: ctl.popRd = 1'b1;
          3'd1: begin ctl.popRd = 1'b1; ctl.popLoCap = 1'b1; end
          3'd2: begin ctl.popRd = 1'b1; ctl.popHiCap = 1'b1; end
          default: ctl.retFin = 1'b1;
        endcase
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int                 NUM_SRC  = 4,
  parameter int                 SRC_W    = 2,
  parameter logic [15:0]        VEC_TOP  = 16'hFFF4,
  parameter logic [15:0]        SP_INIT  = 16'h00FF,
  parameter logic [NUM_SRC-1:0] NMI_MASK = NUM_SRC'(1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [SRC_W-1:0]   srcIdx,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] latchClrSw,
  input  logic               imfWr,
  input  logic               imfWrVal,
  input  logic               spWr,
  input  logic [15:0]        spWrVal,
  input  logic [15:0]        pcIn,
  input  logic [6:0]         pswIn,
  input  logic [7:0]         memRdata,
  output logic [NUM_SRC-1:0] eligible,
  output logic [NUM_SRC-1:0] pend,
  output logic               imf,
  output logic [15:0]        sp,
  output logic [15:0]        memAddr,
  output logic               memWe,
  output logic               memRe,
  output logic [7:0]         memWdata,
  output logic               pcLoad,
  output logic [15:0]        pcOut,
  output logic               pswLoad,
  output logic [6:0]         pswOut,
  output logic               done
);
  logic [NUM_SRC-1:0] latchQ;
  logic [NUM_SRC-1:0] accMask;
  logic               imfQ;
  logic [15:0]        spQ;
  logic [15:0]        snapPc;
  logic [7:0]         snapStat;
  logic [7:0]         byteHold;
  logic [7:0]         popHi;
  logic [15:0]        vecAddr;

  assign accMask  = ctl.latchClr ? (NUM_SRC'(1) << srcIdx) : '0;
  assign eligible = latchQ & (imfQ ? {NUM_SRC{1'b1}} : NMI_MASK);
  assign vecAddr  = VEC_TOP - (16'(srcIdx) << 1) + 16'(ctl.vecLo);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ   <= '0;
      imfQ     <= 1'b0;
      spQ      <= SP_INIT;
      snapPc   <= '0;
      snapStat <= '0;
      byteHold <= '0;
      popHi    <= '0;
    end else begin
      latchQ <= (latchQ & ~latchClrSw & ~accMask) | reqIn;
      if (ctl.swEn && imfWr)  imfQ <= imfWrVal;
      else if (ctl.imfClr)    imfQ <= 1'b0;
      else if (ctl.retFin)    imfQ <= memRdata[7];
      if (ctl.swEn && spWr)   spQ <= spWrVal;
      else if (ctl.push)      spQ <= spQ - 16'd1;
      else if (ctl.popRd)     spQ <= spQ + 16'd1;
      if (ctl.snap) begin
        snapPc   <= pcIn;
        snapStat <= {imfQ, pswIn};
      end
      if (ctl.vecHiCap || ctl.popLoCap) byteHold <= memRdata;
      if (ctl.popHiCap)                 popHi    <= memRdata;
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    if (ctl.push) begin
      memAddr = spQ;
      case (ctl.pushSel)
        2'd0:    memWdata = snapStat;
        2'd1:    memWdata = snapPc[15:8];
        default: memWdata = snapPc[7:0];
      endcase
    end else if (ctl.vecRd) begin
      memAddr = vecAddr;
    end else if (ctl.popRd) begin
      memAddr = spQ + 16'd1;
    end
  end

  assign memWe   = ctl.push;
  assign memRe   = ctl.vecRd | ctl.popRd;
  assign pcLoad  = ctl.entryFin | ctl.retFin;
  assign done    = ctl.entryFin | ctl.retFin;
  assign pcOut   = ctl.entryFin ? {byteHold, memRdata} :
                   ctl.retFin   ? {popHi, byteHold}    : 16'h0000;
  assign pswLoad = ctl.retFin;
  assign pswOut  = ctl.retFin ? memRdata[6:0] : 7'h00;
  assign pend    = latchQ;
  assign imf     = imfQ;
  assign sp      = spQ;

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int          NUM_SRC = 4,
  parameter logic [15:0] VEC_TOP = 16'hFFF4,
  parameter logic [15:0] SP_INIT = 16'h00FF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] latchClr,
  input  logic               instrDone,
  input  logic               retStart,
  input  logic               imfWr,
  input  logic               imfWrVal,
  input  logic               spWr,
  input  logic [15:0]        spWrVal,
  input  logic [15:0]        pcIn,
  input  logic [6:0]         pswIn,
  input  logic [7:0]         memRdata,
  output logic [15:0]        memAddr,
  output logic               memWe,
  output logic               memRe,
  output logic [7:0]         memWdata,
  output logic               pcLoad,
  output logic [15:0]        pcOut,
  output logic               pswLoad,
  output logic [6:0]         pswOut,
  output logic               done,
  output logic               imf,
  output logic [15:0]        sp,
  output logic [NUM_SRC-1:0] pend
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  dpCtl_t             ctl;
  logic [SRC_W-1:0]   srcIdx;
  logic [NUM_SRC-1:0] eligible;

  irq_seq_ctrl #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .retStart(retStart),
    .eligible(eligible), .ctl(ctl), .srcIdx(srcIdx)
  );

  irq_seq_dp #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .VEC_TOP(VEC_TOP), .SP_INIT(SP_INIT),
    .NMI_MASK(NUM_SRC'(1))
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcIdx(srcIdx), .reqIn(reqIn),
    .latchClrSw(latchClr), .imfWr(imfWr), .imfWrVal(imfWrVal), .spWr(spWr),
    .spWrVal(spWrVal), .pcIn(pcIn), .pswIn(pswIn), .memRdata(memRdata),
    .eligible(eligible), .pend(pend), .imf(imf), .sp(sp), .memAddr(memAddr),
    .memWe(memWe), .memRe(memRe), .memWdata(memWdata), .pcLoad(pcLoad),
    .pcOut(pcOut), .pswLoad(pswLoad), .pswOut(pswOut), .done(done)
  );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter logic [15:0] SP_INIT = 16'h00FF
) (
  input logic        clk,
  input logic        rstN,
  input logic        memWe,
  input logic        memRe,
  input logic [15:0] sp,
  input logic        done,
  input logic        pcLoad,
  input logic        pswLoad,
  input logic        imf
);
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R5
  AST_SP_INIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> sp == SP_INIT); // R7
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> sp == $past(sp) - 16'd1); // R5
  AST_DONE_LOADS_PC: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pcLoad); // R6
  AST_PSW_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    pswLoad |-> done); // R8
  AST_IMF_FALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(imf) |-> (!memWe && !memRe)); // R4
endmodule

bind irq_seq irq_seq_chk #(.SP_INIT(SP_INIT)) u_chk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memRe(memRe), .sp(sp),
  .done(done), .pcLoad(pcLoad), .pswLoad(pswLoad), .imf(imf)
);

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] reqIn, latchClr;
  logic         instrDone, retStart, imfWr, imfWrVal, spWr;
  logic [15:0]  spWrVal, pcIn;
  logic [6:0]   pswIn;
  logic [7:0]   memRdata;
  logic [15:0]  memAddr, pcOut, sp;
  logic         memWe, memRe, pcLoad, pswLoad, done, imf;
  logic [7:0]   memWdata;
  logic [6:0]   pswOut;
  logic [N-1:0] pend;

  always #2.5 clk = ~clk;

  irq_seq #(.NUM_SRC(N)) u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .latchClr(latchClr),
    .instrDone(instrDone), .retStart(retStart), .imfWr(imfWr),
    .imfWrVal(imfWrVal), .spWr(spWr), .spWrVal(spWrVal), .pcIn(pcIn),
    .pswIn(pswIn), .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe),
    .memRe(memRe), .memWdata(memWdata), .pcLoad(pcLoad), .pcOut(pcOut),
    .pswLoad(pswLoad), .pswOut(pswOut), .done(done), .imf(imf), .sp(sp),
    .pend(pend)
  );

  // byte memory seen by the block
  bit [7:0] mem [int];
  always @(posedge clk) begin
    if (memWe) mem[int'(memAddr)] = memWdata;
    memRdata <= (memRe && mem.exists(int'(memAddr))) ? mem[int'(memAddr)] : 8'h00;
  end

  // reference model
  typedef struct {
    bit    we, re, dn, pswLd;
    int    addr, wdata, pc, psw, imfSet, spAdd, clr;
    string tag;
  } exp_t;
  exp_t     q[$];
  bit [7:0] shadow [int];
  int       mSp, mImf, mLatch;
  string    seqTag;
  int       errors = 0, checks = 0;

  function automatic exp_t idleE();
    exp_t e;
    e.we = 0; e.re = 0; e.dn = 0; e.pswLd = 0; e.addr = 0; e.wdata = 0;
    e.pc = 0; e.psw = 0; e.imfSet = -1; e.spAdd = 0; e.clr = 0; e.tag = "R2";
    return e;
  endfunction

  function automatic int rdSh(int a);
    return shadow.exists(a & 16'hFFFF) ? int'(shadow[a & 16'hFFFF]) : 0;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic buildEntry(int src);
    exp_t e;
    int sp0 = mSp, v = 16'hFFF4 - 2 * src, st = (mImf << 7) | int'(pswIn);
    e = idleE(); e.tag = "R4"; e.imfSet = 0; q.push_back(e);
    e = idleE(); e.tag = "R4"; e.clr = 1 << src; q.push_back(e);
    e = idleE(); e.tag = "R5"; e.we = 1; e.addr = sp0; e.wdata = st; e.spAdd = -1;
    q.push_back(e); shadow[sp0] = 8'(st);
    e.addr = (sp0 - 1) & 16'hFFFF; e.wdata = int'(pcIn[15:8]);
    q.push_back(e); shadow[e.addr] = 8'(e.wdata);
    e.addr = (sp0 - 2) & 16'hFFFF; e.wdata = int'(pcIn[7:0]);
    q.push_back(e); shadow[e.addr] = 8'(e.wdata);
    e = idleE(); e.tag = seqTag; e.re = 1; e.addr = v; q.push_back(e);
    e.addr = v + 1; q.push_back(e);
    e = idleE(); e.tag = "R6"; e.dn = 1; e.pc = (rdSh(v) << 8) | rdSh(v + 1);
    q.push_back(e);
  endtask

  task automatic buildReturn();
    exp_t e;
    int s = mSp, st;
    for (int k = 1; k <= 3; k++) begin
      e = idleE(); e.tag = seqTag; e.re = 1; e.addr = (s + k) & 16'hFFFF; e.spAdd = 1;
      q.push_back(e);
    end
    st = rdSh(s + 3);
    e = idleE(); e.tag = "R8"; e.dn = 1; e.pc = (rdSh(s + 2) << 8) | rdSh(s + 1);
    e.pswLd = 1; e.psw = st & 8'h7F; e.imfSet = (st >> 7) & 1;
    q.push_back(e);
  endtask

  task automatic tick();
    exp_t e;
    int   elig;
    bit   have = (q.size() > 0);
    e = have ? q[0] : idleE();
    // compare this cycle's outputs
    chk(memWe == e.we, e.tag, "memWe", int'(memWe), int'(e.we));
    chk(memRe == e.re, e.tag, "memRe", int'(memRe), int'(e.re));
    if (e.we || e.re) chk(int'(memAddr) == e.addr, e.tag, "memAddr", int'(memAddr), e.addr);
    if (e.we) chk(int'(memWdata) == e.wdata, e.tag, "memWdata", int'(memWdata), e.wdata);
    chk(done == e.dn && pcLoad == e.dn, e.tag, "done/pcLoad", int'(done), int'(e.dn));
    if (e.dn) chk(int'(pcOut) == e.pc, e.tag, "pcOut", int'(pcOut), e.pc);
    chk(pswLoad == e.pswLd, e.tag, "pswLoad", int'(pswLoad), int'(e.pswLd));
    if (e.pswLd) chk(int'(pswOut) == e.psw, "R8", "pswOut", int'(pswOut), e.psw);
    chk(int'(sp) == mSp, "R5", "sp", int'(sp), mSp);
    chk(int'(imf) == mImf, "R4", "imf", int'(imf), mImf);
    chk(int'(pend) == mLatch, "R1", "pend", int'(pend), mLatch);
    // advance model
    if (have) begin
      void'(q.pop_front());
      if (e.imfSet >= 0) mImf = e.imfSet;
      mSp = (mSp + e.spAdd) & 16'hFFFF;
    end else begin
      elig = mLatch & (mImf != 0 ? 4'hF : 4'h1);
      if (retStart) buildReturn();
      else if (instrDone && elig != 0) begin
        for (int i = N - 1; i >= 0; i--) if (elig[i]) e.addr = i;
        buildEntry(e.addr);
      end else begin
        if (imfWr) mImf = int'(imfWrVal);
        if (spWr)  mSp  = int'(spWrVal);
      end
    end
    mLatch = ((mLatch & ~int'(latchClr) & ~e.clr) | int'(reqIn)) & 4'hF;
    @(posedge clk);
    @(negedge clk);
    reqIn = '0; latchClr = '0; instrDone = 0; retStart = 0; imfWr = 0; spWr = 0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0; reqIn = '0; latchClr = '0; instrDone = 0; retStart = 0;
    imfWr = 0; imfWrVal = 0; spWr = 0; spWrVal = '0;
    pcIn = 16'h1234; pswIn = 7'h15;
    mSp = 16'h00FF; mImf = 0; mLatch = 0; seqTag = "R6";
    for (int i = 0; i < N; i++) begin
      mem[16'hFFF4 - 2 * i] = 8'(8'h40 + 8'h10 * i);
      mem[16'hFFF5 - 2 * i] = 8'(8'h03 + i);
      shadow[16'hFFF4 - 2 * i] = mem[16'hFFF4 - 2 * i];
      shadow[16'hFFF5 - 2 * i] = mem[16'hFFF5 - 2 * i];
    end
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(sp == 16'h00FF, "R7", "reset sp", int'(sp), 16'h00FF);
    chk(imf == 0 && pend == 0, "R7", "reset imf/pend", int'({imf, pend}), 0);
    chk(!memWe && !memRe && !done, "R7", "reset bus", int'({memWe, memRe, done}), 0);
    rstN = 1;
    tick();
    // R9: idle software writes
    imfWr = 1; imfWrVal = 1; spWr = 1; spWrVal = 16'h0240; tick();
    // single maskable source 2
    reqIn = 4'b0100; tick();
    instrDone = 1; tick();
    ticks(10);
    // R8: return restores flag 1
    seqTag = "R8"; retStart = 1; tick(); ticks(6);
    // R2: masked sources wait; R1 clear and same-cycle set
    pcIn = 16'hABCD; pswIn = 7'h6A; seqTag = "R3";
    imfWr = 1; imfWrVal = 0; tick();
    reqIn = 4'b1010; tick();
    instrDone = 1; tick(); instrDone = 1; tick(); instrDone = 1; tick();
    latchClr = 4'b1000; tick();
    reqIn = 4'b0100; latchClr = 4'b0100; tick();
    imfWr = 1; imfWrVal = 1; tick();
    instrDone = 1; tick();                 // R3: source 1 beats source 2
    ticks(2);
    spWr = 1; spWrVal = 16'h1000; tick();  // R9 ignored while busy
    imfWr = 1; imfWrVal = 1; tick();       // R9 ignored while busy
    ticks(6);
    // R3: non-maskable source 0 with flag 0
    reqIn = 4'b0001; tick();
    instrDone = 1; tick();
    ticks(10);
    // R10: return and pending interrupt together
    imfWr = 1; imfWrVal = 1; tick();
    seqTag = "R10"; retStart = 1; instrDone = 1; tick();
    ticks(5);
    seqTag = "R8"; retStart = 1; tick(); ticks(5);
    seqTag = "R6"; instrDone = 1; tick(); ticks(10);
    seqTag = "R8"; retStart = 1; tick(); ticks(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule